// File: doc/BRIEF.md
# Flash Block Protection Gate

This block decides whether a flash program or erase step may turn on the high-voltage charge pump. It also decides whether the protect register may be rewritten. An 8-bit protect value marks where protection starts. Every address from that start up to the top of the flash map is locked. The start address is the protect value shifted left by a parameterized number of zero bits and added to a parameterized array base. With the defaults (base 0xC000, shift 6), the start address is 0xC000 + (value << 6).

The surrounding controller holds a level for program mode or erase mode. A mass-erase select may also be held with erase mode. After entering a mode, the controller must strobe a read of the protect register. After that it may strobe a high-voltage request. The gate answers one cycle later. It either raises a held permit or pulses an error flag. A separate strobe asks to rewrite the protect register. That rewrite is allowed only while the external test-voltage input is high.

Top module: `flash_prot_gate`

## Requirements
- R1: With a protect value V that is neither all zeros nor all ones, an address A is protected exactly when A >= BASE + (V << SHIFT). With the defaults and V = 0x80, 0xDFFF is open and 0xE000 and 0xFFFF are protected.
- R2: A protect value of 0x00 protects every address, including the array base 0xC000.
- R3: A protect value of 0xFF leaves every address unprotected, including the top address 0xFFFF.
- R4: A high-voltage request for program or erase whose target address is protected is denied.
- R5: A request with mass-erase select high is granted only in erase mode and only when the protect value is 0xFF. A mass-erase request with program mode is always denied.
- R6: A request is granted only if a protect-register read strobe was seen in an earlier cycle while the mode was already active. A read made before mode entry does not count. A read made in the same cycle as the request does not count.
- R7: The recorded read is forgotten when both mode levels are low or when op_done is strobed. A new read is then needed.
- R8: A granted request sets hv_permit in the next cycle with err low. A denied request leaves hv_permit low and pulses err high for exactly one cycle.
- R9: Once set, hv_permit stays high until op_done is strobed or both mode levels drop. It is low in the cycle after either event.
- R10: A protect-register rewrite request pulses reg_wr_en for one cycle when test_volt is high. Otherwise it pulses err and leaves reg_wr_en low.
- R11: A high-voltage request is denied when neither mode level is high, or when both are high.
- R12: After reset, hv_permit, reg_wr_en and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_reg | input | 8 | Current protect register value |
| tgt_addr | input | 16 | Target flash address of the operation |
| pgm_mode | input | 1 | Program mode level |
| ers_mode | input | 1 | Erase mode level |
| mass_sel | input | 1 | Mass-erase select level |
| reg_rd | input | 1 | Strobe: protect register was read |
| hv_req | input | 1 | Strobe: request high voltage |
| op_done | input | 1 | Strobe: operation finished |
| reg_wr_req | input | 1 | Strobe: request to rewrite the protect register |
| test_volt | input | 1 | External test voltage present |
| hv_permit | output | 1 | High voltage allowed (held) |
| reg_wr_en | output | 1 | Protect register rewrite allowed (one-cycle pulse) |
| err | output | 1 | Denied request (one-cycle pulse) |

## Verification
The range decode is probed with three protect values: a mid value, all zeros and all ones. For the mid value, targets sit one address below the start, exactly at the start, and at the top address. This separates an off-by-one compare from a correct one and from the two special values. Mass erase is tried with 0xFF, with 0xFE and with program mode. These show that the all-ones rule holds independently of the address compare. The read-order rule is tried in four ways: no read, a read before mode entry, a proper read, and a repeat request after op_done. Together they show that the read flag is qualified by mode and that it is cleared.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   typedef enum logic [1:0] {
      OPK_NONE = 2'b00,
      OPK_PGM  = 2'b01,
      OPK_ERS  = 2'b10,
      OPK_BAD  = 2'b11
   } op_kind_t;

   function automatic op_kind_t decode_op(input logic pgm, input logic ers);
      return op_kind_t'({ers, pgm});
   endfunction
endpackage

// File: rtl/fpg_range.sv
module fpg_range #(
   parameter int          ADDR_W = 16,
   parameter int          REG_W  = 8,
   parameter int          SHIFT  = 6,
   parameter logic [31:0] BASE   = 32'h0000_C000
) (
   input  logic [REG_W-1:0]  prot_reg,
   input  logic [ADDR_W-1:0] addr,
   output logic              all_open,
   output logic              hit
);
   localparam logic [REG_W-1:0] ALL_ONE  = {REG_W{1'b1}};
   localparam longint           MAX_OFS  = ((longint'(1) << REG_W) - 1) << SHIFT;
   localparam longint           MAX_ADDR = (longint'(1) << ADDR_W) - 1;

   generate
      if (REG_W < 1 || SHIFT < 0 || REG_W + SHIFT > ADDR_W)
         $error("fpg_range: REG_W + SHIFT must fit in ADDR_W");
      if (longint'(BASE) + MAX_OFS > MAX_ADDR)
         $error("fpg_range: protected start can overflow the address space");
   endgenerate

   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] start;

   generate
      if (SHIFT == 0) begin : g_noshift
         assign offset = ADDR_W'(prot_reg);
      end else begin : g_shift
         assign offset = ADDR_W'({prot_reg, {SHIFT{1'b0}}});
      end
   endgenerate

   assign start    = BASE[ADDR_W-1:0] + offset;
   assign all_open = (prot_reg == ALL_ONE);

   always_comb begin
      if (all_open)
         hit = 1'b0;
      else if (prot_reg == '0)
         hit = 1'b1;
      else
         hit = (addr >= start);
   end
endmodule

// File: rtl/fpg_hv_seq.sv
module fpg_hv_seq
   import fpg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pgm_mode,
   input  logic ers_mode,
   input  logic reg_rd,
   input  logic hv_req,
   input  logic op_done,
   input  logic blocked,
   output logic hv_permit,
   output logic hv_deny
);
   op_kind_t kind;
   logic     mode_any;
   logic     rd_seen_q;
   logic     rd_seen_d;
   logic     grant;
   logic     permit_d;

   assign kind     = decode_op(pgm_mode, ers_mode);
   assign mode_any = (kind != OPK_NONE);

   always_comb begin
      if (!mode_any || op_done)
         rd_seen_d = 1'b0;
      else if (reg_rd)
         rd_seen_d = 1'b1;
      else
         rd_seen_d = rd_seen_q;
   end

   always_comb begin
      grant = 1'b0;
      if (hv_req && rd_seen_q && !blocked) begin
         unique case (kind)
            OPK_PGM, OPK_ERS: grant = 1'b1;
            default:          grant = 1'b0;
         endcase
      end
   end

   always_comb begin
      if (!mode_any || op_done)
         permit_d = 1'b0;
      else if (grant)
         permit_d = 1'b1;
      else
         permit_d = hv_permit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_seen_q <= 1'b0;
         hv_permit <= 1'b0;
         hv_deny   <= 1'b0;
      end else begin
         rd_seen_q <= rd_seen_d;
         hv_permit <= permit_d;
         hv_deny   <= hv_req && !grant;
      end
   end

   assert_rise_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hv_permit) |-> $past(rd_seen_q));
   assert_permit_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgm_mode && !ers_mode) |=> !hv_permit);
   assert_deny_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hv_deny |-> !$rose(hv_permit));
endmodule

// File: rtl/fpg_regwr.sv
module fpg_regwr (
   input  logic clk,
   input  logic rst_n,
   input  logic reg_wr_req,
   input  logic test_volt,
   output logic reg_wr_en,
   output logic wr_deny
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_wr_en <= 1'b0;
         wr_deny   <= 1'b0;
      end else begin
         reg_wr_en <= reg_wr_req && test_volt;
         wr_deny   <= reg_wr_req && !test_volt;
      end
   end

   assert_regwr_volt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> $past(test_volt));
   assert_regwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && wr_deny));
endmodule

// File: rtl/flash_prot_gate.sv
module flash_prot_gate #(
   parameter int          ADDR_W = 16,
   parameter int          REG_W  = 8,
   parameter int          SHIFT  = 6,
   parameter logic [31:0] BASE   = 32'h0000_C000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  prot_reg,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              pgm_mode,
   input  logic              ers_mode,
   input  logic              mass_sel,
   input  logic              reg_rd,
   input  logic              hv_req,
   input  logic              op_done,
   input  logic              reg_wr_req,
   input  logic              test_volt,
   output logic              hv_permit,
   output logic              reg_wr_en,
   output logic              err
);
   logic all_open;
   logic addr_hit;
   logic blocked;
   logic hv_deny;
   logic wr_deny;

   fpg_range #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .SHIFT(SHIFT), .BASE(BASE)
   ) u_range (
      .prot_reg (prot_reg),
      .addr     (tgt_addr),
      .all_open (all_open),
      .hit      (addr_hit)
   );

   always_comb begin
      if (mass_sel)
         blocked = !(ers_mode && !pgm_mode && all_open);
      else
         blocked = addr_hit;
   end

   fpg_hv_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pgm_mode  (pgm_mode),
      .ers_mode  (ers_mode),
      .reg_rd    (reg_rd),
      .hv_req    (hv_req),
      .op_done   (op_done),
      .blocked   (blocked),
      .hv_permit (hv_permit),
      .hv_deny   (hv_deny)
   );

   fpg_regwr u_regwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr_req (reg_wr_req),
      .test_volt  (test_volt),
      .reg_wr_en  (reg_wr_en),
      .wr_deny    (wr_deny)
   );

   assign err = hv_deny | wr_deny;

   assert_prot_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hv_permit) |-> !$past(addr_hit) || $past(mass_sel));
   assert_mass_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hv_permit) && $past(mass_sel)) |-> ($past(prot_reg) == {REG_W{1'b1}}));
   assert_all_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_reg == {REG_W{1'b1}}) |-> !addr_hit);
   assert_all_shut_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_reg == '0) |-> addr_hit);
endmodule

// File: tb/flash_prot_gate_bench.sv
`timescale 1ns/1ps
module flash_prot_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  prot_reg = 8'hFF;
   logic [15:0] tgt_addr = '0;
   logic        pgm_mode = 0, ers_mode = 0, mass_sel = 0, reg_rd = 0;
   logic        hv_req = 0, op_done = 0, reg_wr_req = 0, test_volt = 0;
   logic        hv_permit, reg_wr_en, err;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   flash_prot_gate u_flash_prot_gate (
      .clk(clk), .rst_n(rst_n), .prot_reg(prot_reg), .tgt_addr(tgt_addr),
      .pgm_mode(pgm_mode), .ers_mode(ers_mode), .mass_sel(mass_sel),
      .reg_rd(reg_rd), .hv_req(hv_req), .op_done(op_done),
      .reg_wr_req(reg_wr_req), .test_volt(test_volt),
      .hv_permit(hv_permit), .reg_wr_en(reg_wr_en), .err(err)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // enter mode, optionally read, request, check answer, leave mode
   task automatic run_op(input string req, input logic pgm, input logic ers, input logic mass,
                         input logic [7:0] pv, input logic [15:0] a, input bit do_rd,
                         input logic exp_grant);
      prot_reg = pv; tgt_addr = a; mass_sel = mass;
      pgm_mode = pgm; ers_mode = ers;
      step();
      reg_rd = do_rd;
      step();
      reg_rd = 0; hv_req = 1;
      step();
      hv_req = 0;
      check(req, "permit", hv_permit, exp_grant);
      check(req, "err", err, !exp_grant);
      step();
      check(req, "err one cycle", err, 1'b0);
      pgm_mode = 0; ers_mode = 0; mass_sel = 0;
      step();
      check(req, "permit after mode clear", hv_permit, 1'b0);
   endtask

   task automatic t_reset();
      check("R12", "permit", hv_permit, 1'b0);
      check("R12", "reg_wr_en", reg_wr_en, 1'b0);
      check("R12", "err", err, 1'b0);
   endtask

   task automatic t_range_mid();
      run_op("R1", 1, 0, 0, 8'h80, 16'hDFFF, 1, 1'b1);
      run_op("R1", 1, 0, 0, 8'h80, 16'hE000, 1, 1'b0);
      run_op("R4", 0, 1, 0, 8'h80, 16'hFFFF, 1, 1'b0);
      run_op("R4", 0, 1, 0, 8'h80, 16'hC100, 1, 1'b1);
   endtask

   task automatic t_extremes();
      run_op("R2", 1, 0, 0, 8'h00, 16'hC000, 1, 1'b0);
      run_op("R2", 0, 1, 0, 8'h00, 16'hD234, 1, 1'b0);
      run_op("R3", 1, 0, 0, 8'hFF, 16'hFFFF, 1, 1'b1);
   endtask

   task automatic t_mass();
      run_op("R5", 0, 1, 1, 8'hFF, 16'hC000, 1, 1'b1);
      run_op("R5", 0, 1, 1, 8'hFE, 16'hC000, 1, 1'b0);
      run_op("R5", 1, 0, 1, 8'hFF, 16'hC000, 1, 1'b0);
   endtask

   task automatic t_read_order();
      run_op("R6", 1, 0, 0, 8'hFF, 16'hC000, 0, 1'b0);
      // read before mode entry must not count
      prot_reg = 8'hFF; tgt_addr = 16'hC000;
      reg_rd = 1;
      step();
      reg_rd = 0; pgm_mode = 1;
      step();
      hv_req = 1;
      step();
      hv_req = 0;
      check("R6", "early read permit", hv_permit, 1'b0);
      check("R6", "early read err", err, 1'b1);
      // read in same cycle as request must not count
      reg_rd = 1; hv_req = 1;
      step();
      reg_rd = 0; hv_req = 0;
      check("R6", "same-cycle read permit", hv_permit, 1'b0);
      pgm_mode = 0;
      step();
   endtask

   task automatic t_hold_and_clear();
      prot_reg = 8'hFF; tgt_addr = 16'hC000; ers_mode = 1;
      step();
      reg_rd = 1;
      step();
      reg_rd = 0; hv_req = 1;
      step();
      hv_req = 0;
      check("R8", "grant permit", hv_permit, 1'b1);
      check("R8", "grant err", err, 1'b0);
      for (int i = 0; i < 4; i++) step();
      check("R9", "permit held", hv_permit, 1'b1);
      op_done = 1;
      step();
      op_done = 0;
      check("R9", "permit after op_done", hv_permit, 1'b0);
      hv_req = 1;
      step();
      hv_req = 0;
      check("R7", "read forgotten after op_done", hv_permit, 1'b0);
      check("R7", "err after op_done", err, 1'b1);
      // mode drop also forgets the read
      reg_rd = 1;
      step();
      reg_rd = 0; ers_mode = 0;
      step();
      ers_mode = 1;
      step();
      hv_req = 1;
      step();
      hv_req = 0;
      check("R7", "read forgotten after mode drop", hv_permit, 1'b0);
      ers_mode = 0;
      step();
   endtask

   task automatic t_bad_mode();
      run_op("R11", 1, 1, 0, 8'hFF, 16'hC000, 1, 1'b0);
      run_op("R11", 0, 0, 0, 8'hFF, 16'hC000, 1, 1'b0);
   endtask

   task automatic t_regwr();
      test_volt = 0; reg_wr_req = 1;
      step();
      reg_wr_req = 0;
      check("R10", "no volt wr_en", reg_wr_en, 1'b0);
      check("R10", "no volt err", err, 1'b1);
      test_volt = 1; reg_wr_req = 1;
      step();
      reg_wr_req = 0;
      check("R10", "volt wr_en", reg_wr_en, 1'b1);
      check("R10", "volt err", err, 1'b0);
      step();
      check("R10", "wr_en one cycle", reg_wr_en, 1'b0);
      test_volt = 0;
   endtask

   initial begin
      step();
      step();
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_range_mid();
      t_extremes();
      t_mass();
      t_read_order();
      t_hold_and_clear();
      t_bad_mode();
      t_regwr();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule